// File: doc/BRIEF.md
# Byte-Register I2C Target with Auto-Increment

This block lets an I2C host reach a byte-wide register space of up to 256 locations held in the surrounding core. SCL and SDA are sampled by the system clock. START and STOP are recognised as SDA edges while SCL is high. Received bits are taken on SCL rising edges, and the block moves SDA only after an SCL falling edge. SDA is open-drain: `sda_o` is tied low and `sda_oe` pulls the line.

One byte-address counter persists across transactions. A write transaction loads it from the sub-address byte that follows the device address. Every data byte written or read then advances it, and it wraps from the top location to zero. Each written byte goes to the core as a one-cycle strobe, unless the location is flagged read-only. Reads take `reg_rdata` for the current counter value. So a read transaction with no sub-address continues from wherever the last transaction left the counter. A random read is a sub-address write followed by a repeated START with the read bit set.

The state machine has nine states:
- `ST_IDLE`: ignore the bus until START.
- `ST_DEV`: shift in the device byte.
- `ST_DEV_ACK`: acknowledge the device byte.
- `ST_SUB`: shift in the sub-address.
- `ST_SUB_ACK`: acknowledge the sub-address and load the counter.
- `ST_WR`: shift in a data byte.
- `ST_WR_ACK`: acknowledge the data byte.
- `ST_RD`: shift out a data byte.
- `ST_RD_ACK`: sample the host's acknowledge.

Transitions:
- START from any state goes to `ST_DEV`.
- STOP from any state goes to `ST_IDLE`.
- `ST_DEV` goes to `ST_DEV_ACK` on an address hit. On a miss it returns to `ST_IDLE`.
- `ST_DEV_ACK` goes to `ST_SUB` for a write or to `ST_RD` for a read.
- `ST_SUB` goes to `ST_SUB_ACK`, and `ST_SUB_ACK` goes to `ST_WR`.
- `ST_WR` and `ST_WR_ACK` alternate.
- `ST_RD` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes back to `ST_RD` on ACK, or to `ST_IDLE` on NACK.

Apart from START and STOP, every transition happens on an SCL falling edge.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset `sda_oe` is 0, `reg_we` is 0 and `reg_raddr` is 0.
- R2: The block pulls SDA low in the ninth clock of the first byte only when that byte's upper seven bits equal `DEV_ADDR`. Bit 0 of that byte is the direction: 0 means write, 1 means read. On a mismatch the block leaves SDA released and issues no write until the next START.
- R3: In a write transaction the second byte is the sub-address. Each following byte is acknowledged and written to consecutive locations starting at that sub-address. Write data is taken MSB first.
- R4: The byte counter advances by one after every data byte written or read and wraps from 255 to 0. The `reg_raddr` port shows the counter, so after a write strobe `reg_raddr` equals `reg_waddr + 1`.
- R5: A read transaction without a preceding sub-address returns bytes from the counter value left by the previous transaction.
- R6: A random read returns bytes MSB first from successive locations. A host ACK (SDA low) continues the read. After a host NACK (SDA high) the block releases SDA and ignores the bus until START.
- R7: A byte written to a location whose bit is set in `RO_MASK` produces no `reg_we`. The byte is still acknowledged and the counter still advances. By default locations 240 to 255 are read-only.
- R8: `sda_oe` changes only while SCL is low. A STOP returns the block to idle with SDA released and no write issued.
- R9: Each written byte yields exactly one `reg_we` pulse, one clock long. It carries `reg_waddr` equal to the counter value before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA output value, always 0 (open drain) |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_raddr | output | ADDR_W | Byte counter, read address toward the core |
| reg_rdata | input | 8 | Core data at `reg_raddr`, valid within one SCL period |
| reg_waddr | output | ADDR_W | Write address toward the core |
| reg_wdata | output | 8 | Write data toward the core |
| reg_we | output | 1 | One-cycle write strobe |

## Verification
On every cycle the checker verifies four things: that no write strobe reaches a read-only location, that strobes last one clock, that the counter sits one past the written address during a strobe, and that SDA drive moves only while SCL is low. Only the bench's transactions can show the values themselves. These are the acknowledge decisions on address hit and miss, the data returned by random and current-address reads, and the counter's wrap at 255. A full 256-location write sweep, followed by a 258-byte read-back across the wrap point, compares every location against a model computed in the bench.

// File: rtl/i2c_regslv_pkg.sv
package i2c_regslv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } slv_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_cond.sv
// Synchronises SCL/SDA and derives edge and bus-condition strobes.
module i2c_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop,
    output logic sda_bit
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_now;
    logic                   sda_now;

    assign scl_now = scl_pipe[LAST];
    assign sda_now = sda_pipe[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
            sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign bus_start = scl_now & scl_prev & sda_prev & ~sda_now;
    assign bus_stop  = scl_now & scl_prev & ~sda_prev & sda_now;
    assign sda_bit   = sda_now;

endmodule

// File: rtl/i2c_addr_ctr.sv
// Persistent byte-address counter: load has priority, increment wraps.
module i2c_addr_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (inc)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/i2c_slave_fsm.sv
// Protocol state machine: address match, sub-address, data shifting, ACK.
module i2c_slave_fsm
    import i2c_regslv_pkg::*;
#(
    parameter int                     ADDR_W   = 8,
    parameter logic [6:0]             DEV_ADDR = 7'h3C,
    parameter logic [(1<<ADDR_W)-1:0] RO_MASK  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              sda_bit,
    input  logic [ADDR_W-1:0] ctr,
    input  logic [7:0]        rd_byte,
    output logic              ctr_load,
    output logic [ADDR_W-1:0] ctr_load_val,
    output logic              ctr_inc,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);

    slv_state_e state_q, state_d;
    logic [3:0] bit_cnt_q;
    logic [7:0] shreg_q, shreg_d;
    logic       rw_q;
    logic       host_ack_q;
    logic       byte_done;
    logic       rx_state;
    logic       addr_hit;
    logic       ack_drive;
    logic       wr_done;

    assign byte_done = (bit_cnt_q == BITS_PER_BYTE);
    assign rx_state  = (state_q == ST_DEV) || (state_q == ST_SUB) || (state_q == ST_WR);
    assign addr_hit  = (shreg_q[7:1] == DEV_ADDR);
    assign wr_done   = scl_fall && byte_done && (state_q == ST_WR);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (bus_stop) begin
            state_d = ST_IDLE;
        end else if (bus_start) begin
            state_d = ST_DEV;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_DEV:     if (scl_fall && byte_done) state_d = addr_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK: if (scl_fall) state_d = rw_q ? ST_RD : ST_SUB;
                ST_SUB:     if (scl_fall && byte_done) state_d = ST_SUB_ACK;
                ST_SUB_ACK: if (scl_fall) state_d = ST_WR;
                ST_WR:      if (scl_fall && byte_done) state_d = ST_WR_ACK;
                ST_WR_ACK:  if (scl_fall) state_d = ST_WR;
                ST_RD:      if (scl_fall && byte_done) state_d = ST_RD_ACK;
                ST_RD_ACK:  if (scl_fall) state_d = host_ack_q ? ST_RD : ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // shift register next value: receive on rise, load/shift out on fall
    always_comb begin
        shreg_d = shreg_q;
        if (scl_rise && rx_state)
            shreg_d = {shreg_q[6:0], sda_bit};
        else if (state_d == ST_RD && state_q != ST_RD)
            shreg_d = rd_byte;
        else if (state_q == ST_RD && scl_fall && !byte_done)
            shreg_d = {shreg_q[6:0], 1'b0};
    end

    assign ack_drive = (state_d == ST_DEV_ACK) || (state_d == ST_SUB_ACK) ||
                       (state_d == ST_WR_ACK);

    assign ctr_load     = scl_fall && (state_q == ST_SUB_ACK);
    assign ctr_load_val = ADDR_W'(shreg_q);
    assign ctr_inc      = scl_fall && byte_done && ((state_q == ST_WR) || (state_q == ST_RD));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            shreg_q    <= '0;
            rw_q       <= 1'b0;
            host_ack_q <= 1'b0;
        end else begin
            shreg_q <= shreg_d;
            if (bus_start || (state_d != state_q))
                bit_cnt_q <= '0;
            else if (scl_rise && (rx_state || state_q == ST_RD))
                bit_cnt_q <= bit_cnt_q + 1'b1;
            if (state_q == ST_DEV && state_d == ST_DEV_ACK)
                rw_q <= shreg_q[0];
            if (state_q == ST_RD_ACK && scl_rise)
                host_ack_q <= ~sda_bit;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            sda_oe <= ack_drive || (state_d == ST_RD && !shreg_d[7]);
            wr_en  <= wr_done && !RO_MASK[ctr];
            if (wr_done) begin
                wr_addr <= ctr;
                wr_data <= shreg_q;
            end
        end
    end

endmodule

// File: rtl/i2c_reg_slave.sv
// Top: I2C target giving byte access to a core register space.
module i2c_reg_slave #(
    parameter int                     ADDR_W      = 8,
    parameter int                     SYNC_STAGES = 2,
    parameter logic [6:0]             DEV_ADDR    = 7'h3C,
    parameter logic [(1<<ADDR_W)-1:0] RO_MASK     = {{16{1'b1}}, {((1<<ADDR_W)-16){1'b0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_raddr,
    input  logic [7:0]        reg_rdata,
    output logic [ADDR_W-1:0] reg_waddr,
    output logic [7:0]        reg_wdata,
    output logic              reg_we
);
    logic              scl_rise, scl_fall, bus_start, bus_stop, sda_bit;
    logic              ctr_load, ctr_inc;
    logic [ADDR_W-1:0] ctr_load_val;
    logic [ADDR_W-1:0] ctr;

    assign sda_o     = 1'b0;
    assign reg_raddr = ctr;

    i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop),
        .sda_bit  (sda_bit)
    );

    i2c_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ctr_load),
        .load_val(ctr_load_val),
        .inc     (ctr_inc),
        .count   (ctr)
    );

    i2c_slave_fsm #(
        .ADDR_W  (ADDR_W),
        .DEV_ADDR(DEV_ADDR),
        .RO_MASK (RO_MASK)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .bus_start   (bus_start),
        .bus_stop    (bus_stop),
        .sda_bit     (sda_bit),
        .ctr         (ctr),
        .rd_byte     (reg_rdata),
        .ctr_load    (ctr_load),
        .ctr_load_val(ctr_load_val),
        .ctr_inc     (ctr_inc),
        .sda_oe      (sda_oe),
        .wr_en       (reg_we),
        .wr_addr     (reg_waddr),
        .wr_data     (reg_wdata)
    );

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
    parameter int                     ADDR_W  = 8,
    parameter logic [(1<<ADDR_W)-1:0] RO_MASK = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_waddr,
    input logic [ADDR_W-1:0] reg_raddr
);
    // R7
    ro_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !RO_MASK[reg_waddr]);

    // R9
    we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R4
    ctr_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_raddr == ADDR_W'(reg_waddr + 1'b1)));

    // R8
    sda_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_i));
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.ADDR_W(ADDR_W), .RO_MASK(RO_MASK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_waddr(reg_waddr),
    .reg_raddr(reg_raddr)
);

// File: tb/i2c_reg_slave_test.sv
`timescale 1ns/1ps
module i2c_reg_slave_test;
    localparam int         Q     = 5;
    localparam logic [6:0] DEV   = 7'h3C;
    localparam int         RO_LO = 240;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda_low = 1'b0;
    logic       sda_o, sda_oe, reg_we;
    logic [7:0] reg_raddr, reg_waddr, reg_wdata, reg_rdata;
    logic       sda_bus;
    logic [7:0] core_mem [256];
    logic [7:0] exp_mem  [256];
    int         checks = 0, failures = 0, we_cnt = 0, cyc = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    assign sda_bus   = !(m_sda_low || (sda_oe && !sda_o));
    assign reg_rdata = core_mem[reg_raddr];

    i2c_reg_slave #(.DEV_ADDR(DEV)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_o(sda_o), .sda_oe(sda_oe), .reg_raddr(reg_raddr),
        .reg_rdata(reg_rdata), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_we(reg_we)
    );

    // core register-space model
    initial for (int a = 0; a < 256; a++) core_mem[a] = ~8'(a);
    always @(posedge clk) if (reg_we) core_mem[reg_waddr] <= reg_wdata;
    always @(negedge clk) if (reg_we) we_cnt++;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda_low = 1'b0; wq();
        m_scl = 1'b1;     wq();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b0;     wq();
    endtask

    task automatic i2c_stop();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b1;     wq();
        m_sda_low = 1'b0; wq();
    endtask

    task automatic i2c_bit(input logic drive_low, output logic seen);
        m_sda_low = drive_low; wq();
        m_scl = 1'b1;          wq();
        seen = sda_bus;        wq();
        m_scl = 1'b0;          wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) i2c_bit(!b[i], s);
        i2c_bit(1'b0, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            i2c_bit(1'b0, s);
            b[i] = s;
        end
        i2c_bit(give_ack, s);
    endtask

    function automatic bit is_ro(input int a);
        return a >= RO_LO;
    endfunction

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] b;
        int         we_base, exp_we;
        for (int a = 0; a < 256; a++) exp_mem[a] = ~8'(a);

        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 sda_oe", sda_oe, 0);
        check("R1 reg_we", reg_we, 0);
        check("R1 reg_raddr", reg_raddr, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 address mismatch: no ACK, no writes
        we_base = we_cnt;
        i2c_start();
        send_byte({7'h2A, 1'b0}, ack);
        check("R2 mismatch nack", ack, 0);
        send_byte(8'h05, ack);
        check("R2 ignored byte", ack, 0);
        send_byte(8'h99, ack);
        i2c_stop();
        check("R2 no write", we_cnt - we_base, 0);

        // R8 STOP right after address ACK
        i2c_start();
        send_byte({DEV, 1'b0}, ack);
        check("R2 match ack", ack, 1);
        i2c_stop();
        check("R8 released after stop", sda_oe, 0);
        check("R8 no write", we_cnt - we_base, 0);

        // R3 / R9 short write burst
        i2c_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h10, ack);
        check("R3 subaddr ack", ack, 1);
        send_byte(8'hA5, ack); check("R3 data0 ack", ack, 1);
        send_byte(8'h5A, ack); check("R3 data1 ack", ack, 1);
        send_byte(8'hC3, ack); check("R3 data2 ack", ack, 1);
        i2c_stop();
        exp_mem[8'h10] = 8'hA5; exp_mem[8'h11] = 8'h5A; exp_mem[8'h12] = 8'hC3;
        check("R9 one strobe per byte", we_cnt - we_base, 3);
        check("R4 counter after write", reg_raddr, 8'h13);

        // R6 random read
        i2c_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h10, ack);
        i2c_start();
        send_byte({DEV, 1'b1}, ack);
        check("R6 read addr ack", ack, 1);
        recv_byte(1'b1, b); check("R6 rd0", b, exp_mem[8'h10]);
        recv_byte(1'b1, b); check("R6 rd1", b, exp_mem[8'h11]);
        recv_byte(1'b0, b); check("R6 rd2", b, exp_mem[8'h12]);
        check("R6 released after nack", sda_oe, 0);
        i2c_stop();
        check("R4 counter after read", reg_raddr, 8'h13);

        // R5 current-address read
        i2c_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, b);
        i2c_stop();
        check("R5 current read", b, exp_mem[8'h13]);
        check("R4 counter after current read", reg_raddr, 8'h14);

        // R3 / R4 / R7 full sweep write with wrap
        we_base = we_cnt;
        exp_we  = 0;
        i2c_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h00, ack);
        for (int i = 0; i <= 256; i++) begin
            logic [7:0] d;
            d = (i == 256) ? 8'h77 : 8'((i * 37 + 11) & 255);
            send_byte(d, ack);
            check("R7 sweep ack", ack, 1);
            if (!is_ro(i & 255)) begin
                exp_mem[i & 255] = d;
                exp_we++;
            end
        end
        i2c_stop();
        check("R7 strobes skip read-only", we_cnt - we_base, exp_we);
        check("R4 wrap after write", reg_raddr, 1);

        // R4 / R6 / R7 read-back across wrap
        i2c_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h00, ack);
        i2c_start();
        send_byte({DEV, 1'b1}, ack);
        for (int i = 0; i < 258; i++) begin
            recv_byte(i != 257, b);
            check("R4 R7 sweep readback", b, exp_mem[i & 255]);
        end
        check("R6 released at end", sda_oe, 0);
        i2c_stop();
        check("R4 counter wrapped", reg_raddr, 2);

        // R5 continue from persisted counter
        i2c_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b1, b); check("R5 persisted rd0", b, exp_mem[2]);
        recv_byte(1'b0, b); check("R5 persisted rd1", b, exp_mem[3]);
        i2c_stop();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule